// File: doc/BRIEF.md
# Variable-Latency Speculative Booth Multiplier

This block multiplies two signed two's-complement operands of `N` bits and returns the full `2N`-bit signed product. The multiplier operand is recoded into radix-4 modified Booth digits, which gives `N/2` partial products. Their sum is cut at column `N-Z`. The lower `N-Z` columns and the upper `N+Z` columns are added side by side.

The carry from the lower section into the upper section is not waited for. It is estimated from only the top `EST_COLS` columns of each lower partial product. That estimate is added into the upper section in the same cycle as the accumulation. When the estimate equals the true carry, the product is ready after one cycle. When it does not, the upper sum is held in registers for one more cycle and corrected by the carry error before delivery. A `mispredict` flag tells the surrounding datapath which case occurred.

A client presents operands with `start` while `ready` is high. It then waits for the one-cycle `done` strobe, which comes with `product` and `mispredict`.

Top module: `vlsb_mult`

## Requirements
- R1: When `done` is high, `product` equals the exact signed product `op_a * op_b` of the accepted operands, as a `2N`-bit two's-complement value. This includes the most negative operand values.
- R2: The carry estimate never exceeds the true carry out of the low `N-Z` columns. The estimate is the sum of bits `[N-Z-1 : N-Z-EST_COLS]` of every partial product, shifted right by `EST_COLS`.
- R3: When the estimate is correct, `done` is high in the cycle right after the cycle in which `start` was accepted, and `mispredict` is low.
- R4: When the estimate is wrong, `done` is high two cycles after the accepting cycle, and `mispredict` is high in that same cycle.
- R5: `done` is high for exactly one cycle per accepted multiplication, and `mispredict` is never high without `done`.
- R6: `ready` is low during the correcting cycle. A `start` that is high while `ready` is low is ignored and produces no result.
- R7: After reset, `ready` is high and both `done` and `mispredict` are low.
- R8: `start` is accepted in any cycle where `ready` is high, including the cycle in which the previous result's `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication of `op_a` and `op_b` |
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier (Booth recoded), two's complement |
| ready | output | 1 | High when a `start` will be accepted |
| done | output | 1 | One-cycle strobe: `product` is valid |
| mispredict | output | 1 | High with `done` when the correcting cycle was used |
| product | output | 2N | Signed product |

## Verification
The hardest case to reach is a start request arriving during the correcting cycle. It can only happen after a misprediction, and whether a pair of operands mispredicts depends on how carries ripple through the low columns. The stimulus therefore sends random operand pairs one after another. Each time, it looks at `ready` in the following cycle. The first time `ready` is low, it drives `start` with different operands during that cycle. It then checks that only the original result comes out and that no extra `done` follows. Latency is checked against `mispredict` for every product, and the run must show both the one-cycle and the two-cycle outcome.

// File: rtl/vlsb_pkg.sv
package vlsb_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_FIX  = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        DG_ZERO,
        DG_POS1,
        DG_POS2,
        DG_NEG1,
        DG_NEG2
    } digit_e;

    // Radix-4 Booth recoding of a bit triplet {b[2i+1], b[2i], b[2i-1]}
    function automatic digit_e recode(input logic [2:0] trip);
        case (trip)
            3'b001, 3'b010: return DG_POS1;
            3'b011:         return DG_POS2;
            3'b100:         return DG_NEG2;
            3'b101, 3'b110: return DG_NEG1;
            default:        return DG_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/vlsb_booth_pp.sv
module vlsb_booth_pp
    import vlsb_pkg::*;
#(
    parameter int N = 16,
    localparam int NPP = N / 2,
    localparam int PW  = 2 * N
) (
    input  logic [N-1:0]            a_in,
    input  logic [N-1:0]            b_in,
    output logic [NPP-1:0][PW-1:0]  pp_out
);

    logic [PW-1:0] a_ext;
    assign a_ext = {{N{a_in[N-1]}}, a_in};

    for (genvar g = 0; g < NPP; g++) begin : g_digit
        logic [2:0]    trip;
        logic [PW-1:0] mult;

        if (g == 0) begin : g_first
            assign trip = {b_in[1], b_in[0], 1'b0};
        end else begin : g_rest
            assign trip = {b_in[2*g+1], b_in[2*g], b_in[2*g-1]};
        end

        always_comb begin
            case (recode(trip))
                DG_POS1: mult = a_ext;
                DG_POS2: mult = a_ext << 1;
                DG_NEG1: mult = -a_ext;
                DG_NEG2: mult = -(a_ext << 1);
                default: mult = '0;
            endcase
        end

        assign pp_out[g] = mult << (2 * g);
    end

endmodule

// File: rtl/vlsb_split_accum.sv
module vlsb_split_accum #(
    parameter int N        = 16,
    parameter int Z        = 2,
    parameter int EST_COLS = 3,
    localparam int NPP = N / 2,
    localparam int PW  = 2 * N,
    localparam int S   = N - Z,
    localparam int HW  = N + Z,
    localparam int CW  = $clog2(NPP) + 1
) (
    input  logic [NPP-1:0][PW-1:0] pp_in,
    output logic [S-1:0]           low_bits,
    output logic [HW-1:0]          high_spec,
    output logic [CW-1:0]          carry_true,
    output logic [CW-1:0]          carry_pred
);

    logic [S+CW-1:0]        low_acc;
    logic [EST_COLS+CW-1:0] est_acc;
    logic [HW-1:0]          high_acc;

    // Full low-section sum: the true carry is everything above column S
    always_comb begin
        low_acc = '0;
        for (int i = 0; i < NPP; i++) begin
            low_acc = low_acc + (S+CW)'(pp_in[i][S-1:0]);
        end
    end

    // Estimate: only the top EST_COLS columns, ripple from below ignored
    always_comb begin
        est_acc = '0;
        for (int i = 0; i < NPP; i++) begin
            est_acc = est_acc + (EST_COLS+CW)'(pp_in[i][S-1 -: EST_COLS]);
        end
    end

    // Upper section, accumulated with the predicted carry-in
    always_comb begin
        high_acc = HW'(carry_pred);
        for (int i = 0; i < NPP; i++) begin
            high_acc = high_acc + pp_in[i][PW-1:S];
        end
    end

    assign low_bits   = low_acc[S-1:0];
    assign carry_true = low_acc[S+CW-1:S];
    assign carry_pred = est_acc[EST_COLS+CW-1:EST_COLS];
    assign high_spec  = high_acc;

endmodule

// File: rtl/vlsb_mult.sv
module vlsb_mult
    import vlsb_pkg::*;
#(
    parameter int N        = 16,
    parameter int Z        = 2,
    parameter int EST_COLS = 3,
    localparam int NPP = N / 2,
    localparam int PW  = 2 * N,
    localparam int S   = N - Z,
    localparam int HW  = N + Z,
    localparam int CW  = $clog2(NPP) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  op_a,
    input  logic [N-1:0]  op_b,
    output logic          ready,
    output logic          done,
    output logic          mispredict,
    output logic [PW-1:0] product
);

    typedef struct packed {
        phase_e        phase;
        logic          done;
        logic          miss;
        logic [HW-1:0] high;
        logic [S-1:0]  low;
        logic [CW-1:0] err;
        logic [PW-1:0] prod;
    } state_t;

    logic [NPP-1:0][PW-1:0] pp;
    logic [S-1:0]           low_bits;
    logic [HW-1:0]          high_spec;
    logic [CW-1:0]          carry_true;
    logic [CW-1:0]          carry_pred;
    logic                   accept;
    state_t                 st_d, st_q;

    vlsb_booth_pp #(.N(N)) u_pp (
        .a_in   (op_a),
        .b_in   (op_b),
        .pp_out (pp)
    );

    vlsb_split_accum #(.N(N), .Z(Z), .EST_COLS(EST_COLS)) u_acc (
        .pp_in      (pp),
        .low_bits   (low_bits),
        .high_spec  (high_spec),
        .carry_true (carry_true),
        .carry_pred (carry_pred)
    );

    assign accept = start && (st_q.phase == PH_IDLE);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.miss = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    if (carry_true == carry_pred) begin
                        st_d.prod = {high_spec, low_bits};
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = PH_FIX;
                        st_d.high  = high_spec;
                        st_d.low   = low_bits;
                        st_d.err   = carry_true - carry_pred;
                    end
                end
            end
            PH_FIX: begin
                st_d.prod  = {st_q.high + HW'(st_q.err), st_q.low};
                st_d.done  = 1'b1;
                st_d.miss  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = (st_q.phase == PH_IDLE);
    assign done       = st_q.done;
    assign mispredict = st_q.miss;
    assign product    = st_q.prod;

    // Estimate from truncated columns can only under-count the carry
    p_est_le_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (carry_pred <= carry_true));

    // Correct estimate: result next cycle, no flag
    p_hit_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && carry_true == carry_pred) |=> (done && !mispredict && ready));

    // Wrong estimate: one correcting cycle with ready low, then flagged result
    p_miss_two_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && carry_true != carry_pred) |=> (!ready && !done) ##1 (done && mispredict));

    // Flag only with the strobe
    p_flag_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> done);

    // Every strobe traces back to an accepted start or a correcting cycle
    p_done_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(accept) || $past(st_q.phase == PH_FIX)));

    // Start while busy does not extend the operation
    p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start) |=> (ready && done && mispredict));

endmodule

// File: tb/vlsb_mult_bench.sv
module vlsb_mult_bench;

    localparam int N  = 16;
    localparam int PW = 2 * N;

    typedef struct {
        logic [N-1:0]  a;
        logic [N-1:0]  b;
        logic [PW-1:0] exp;
        int            cyc;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  op_a = '0;
    logic [N-1:0]  op_b = '0;
    logic          ready;
    logic          done;
    logic          mispredict;
    logic [PW-1:0] product;

    item_t q[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    int    n_hit = 0;
    int    n_miss = 0;
    bit    ended = 0;
    bit    run_mon = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    vlsb_mult #(.N(N)) u_vlsb_mult (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_a       (op_a),
        .op_b       (op_b),
        .ready      (ready),
        .done       (done),
        .mispredict (mispredict),
        .product    (product)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [PW-1:0] ea, eb;
        ea = {{N{a[N-1]}}, a};
        eb = {{N{b[N-1]}}, b};
        return ea * eb;
    endfunction

    // Driver: waits for ready, drives a request for one cycle, records expectation
    task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b);
        item_t it;
        @(negedge clk);
        start = 1'b0;
        while (!ready) @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        it.a = a; it.b = b; it.exp = ref_mul(a, b); it.cyc = cyc;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (run_mon) begin
            if (mispredict && !done)
                check(1'b0, "R5 flag without done", 64'(mispredict), 64'(0));
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R5/R6 unexpected done", 64'(product), 64'(0));
                end else begin
                    item_t it;
                    int lat;
                    it  = q.pop_front();
                    lat = cyc - it.cyc;
                    check(product == it.exp, "R1 product", 64'(product), 64'(it.exp));
                    if (mispredict) begin
                        n_miss++;
                        check(lat == 2, "R4 latency on mispredict", 64'(lat), 64'(2));
                    end else begin
                        n_hit++;
                        check(lat == 1, "R3 latency on correct estimate", 64'(lat), 64'(1));
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'(cyc), 64'(0));
        finish_run();
    end

    initial begin : stim
        bit found;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check(ready == 1'b1, "R7 ready after reset", 64'(ready), 64'(1));
        check(done == 1'b0, "R7 done after reset", 64'(done), 64'(0));
        check(mispredict == 1'b0, "R7 mispredict after reset", 64'(mispredict), 64'(0));
        run_mon = 1;

        // R1 directed corners, including most negative values
        issue(16'h0000, 16'h0000);
        issue(16'h0001, 16'h0001);
        issue(16'h8000, 16'h8000);
        issue(16'h8000, 16'h7FFF);
        issue(16'h7FFF, 16'h8000);
        issue(16'h7FFF, 16'h7FFF);
        issue(16'hFFFF, 16'h0005);
        issue(16'hFFFF, 16'hFFFF);
        issue(16'h8000, 16'hFFFF);
        issue(16'h5555, 16'hAAAA);
        idle();
        repeat (4) @(negedge clk);

        // R8: back-to-back random requests
        for (int i = 0; i < 600; i++) begin
            issue(16'($urandom), 16'($urandom));
        end
        idle();
        repeat (4) @(negedge clk);

        // R6: start during the correcting cycle must be ignored
        found = 0;
        for (int i = 0; i < 400 && !found; i++) begin
            issue(16'($urandom), 16'($urandom));
            @(negedge clk);
            start = 1'b0;
            if (!ready) begin
                found = 1;
                check(ready == 1'b0, "R6 ready low while correcting", 64'(ready), 64'(0));
                op_a  = 16'h1234;
                op_b  = 16'h4321;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        check(found, "R6 correcting cycle reached", 64'(found), 64'(1));
        repeat (5) @(negedge clk);
        check(q.size() == 0, "R6 no pending or extra result", 64'(q.size()), 64'(0));

        // R2/R3/R4: both outcomes occurred across the run
        check(n_hit > 0, "R3 correct-estimate outcome seen", 64'(n_hit), 64'(1));
        check(n_miss > 0, "R4 mispredict outcome seen", 64'(n_miss), 64'(1));
        check(n_hit + n_miss > 0, "R2 results observed", 64'(n_hit + n_miss), 64'(1));
        finish_run();
    end

endmodule